// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port through which a host microcontroller reads and writes a bank of eight 8-bit control registers. The host lowers a select line and clocks bits in on a serial data input. The block returns read data on a serial data output, with a separate output-enable that stands in for a tri-state driver. The register contents are presented in parallel on a flat output bus, which feeds the datapath that the registers control.

A transaction is one low period of the select line. The first eight bits form a command byte. Bit 7 of that byte is the direction (1 = read, 0 = write), bits 2..0 are the register address, and bits 6..3 are ignored. Every later byte in the same low period is data for that one register. A static strap sets the bit order for every byte: LSB first (D0 arrives first) or MSB first (D7 arrives first).

All serial inputs are brought into the system clock domain through a synchronizer, and their edges are detected there. As a result, every register and output change happens a fixed three system clocks after the matching pin change.

Top module: `ser_reg_port`

## Requirements
- R1: After reset, all eight registers read 0x00, `ser_oe` is 0 and `ser_out` is 0.
- R2: Input bits are captured on rising edges of `ser_clk`. On a write, the data byte is stored in the addressed register once its eighth bit has been captured.
- R3: In the command byte, bit 7 selects the direction (1 = read, 0 = write) and bits 2..0 select the register. Bits 6..3 have no effect, and the command byte itself never changes a register.
- R4: On a read, the addressed register's bits appear on `ser_out`. The first bit appears at the first falling edge of `ser_clk` after the command byte, and `ser_out` changes only after falling edges.
- R5: `ser_oe` is 0 while `sel_n` is high and throughout the command byte. It is 1 during the data phase of a read.
- R6: With `order_lsb` = 1, every byte in both directions moves D0 first. With `order_lsb` = 0, every byte moves D7 first.
- R7: Several data bytes after one command all address the same register. Repeated writes leave the last byte stored, and repeated reads return the same value again.
- R8: If `sel_n` rises before all eight bits of a data byte have arrived, the partial byte is discarded and the register keeps its old value.
- R9: A new command byte is recognised only after `sel_n` has gone high and then low again. A byte that follows the data phase is data, even if it has the form of a command.
- R10: A write changes only the addressed register, and a read changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_lsb | input | 1 | Bit-order strap: 1 = LSB first, 0 = MSB first |
| sel_n | input | 1 | Active-low transaction select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial data from the host, captured on rising edges |
| ser_out | output | 1 | Serial read data, updated after falling edges |
| ser_oe | output | 1 | Drive enable for `ser_out` |
| reg_image | output | 64 | All registers, register n in bits [8n+7:8n] |

## Verification
The assertions assume that the strap changes only while `sel_n` is high, and that `sel_n` moves only while `ser_clk` is low. They also assume that each level of `ser_clk` lasts longer than the three-clock synchroniser latency, so that a rising edge and a falling edge are never seen in the same system cycle. The stimulus holds each serial clock level for six system clocks, changes the data input only while the serial clock is low, and switches the strap only between transactions.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {DEPTH{INIT}};
        else        pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/srp_regbank.sv
module srp_regbank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [DATA_W-1:0]            rdata,
    output logic [(2**ADDR_W)*DATA_W-1:0] image
);
    localparam int NUM_REGS = 2 ** ADDR_W;

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = regs_q[raddr];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_image
        assign image[g*DATA_W +: DATA_W] = regs_q[g];
    end

endmodule

// File: rtl/srp_txshift.sv
module srp_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              lsb_first,
    output logic              bit_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              bit_out;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.word = load_val;
        end else if (shift) begin
            if (lsb_first) begin
                tx_d.bit_out = tx_q.word[0];
                tx_d.word    = tx_q.word >> 1;
            end else begin
                tx_d.bit_out = tx_q.word[DATA_W-1];
                tx_d.word    = tx_q.word << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign bit_o = tx_q.bit_out;

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import srp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          order_lsb,
    input  logic                          sel_n,
    input  logic                          ser_clk,
    input  logic                          ser_in,
    output logic                          ser_out,
    output logic                          ser_oe,
    output logic [(2**ADDR_W)*DATA_W-1:0] reg_image
);
    localparam int CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int LAST_BIT = DATA_W - 1;
    localparam int RD_BIT   = DATA_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        phase_e            phase;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rx;
        logic              oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic sel_s, sel_rise_unused, sel_fall_unused;
    logic sck_s, sck_rise, sck_fall;
    logic din_s, din_rise_unused, din_fall_unused;

    srp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .async_i(sel_n),
        .level_o(sel_s), .rise_o(sel_rise_unused), .fall_o(sel_fall_unused)
    );
    srp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .async_i(ser_clk),
        .level_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall)
    );
    srp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .async_i(ser_in),
        .level_o(din_s), .rise_o(din_rise_unused), .fall_o(din_fall_unused)
    );

    logic [DATA_W-1:0] rx_next;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en, tx_load, tx_shift, tx_bit;
    logic              in_cmd, rd_flag;

    always_comb begin
        if (order_lsb) rx_next = {din_s, ctl_q.rx[DATA_W-1:1]};
        else           rx_next = {ctl_q.rx[DATA_W-2:0], din_s};
    end

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        rd_addr  = ctl_q.addr;
        if (ctl_q.phase == PH_CMD) rd_addr = rx_next[ADDR_W-1:0];

        if (sel_s) begin
            ctl_d.cnt   = '0;
            ctl_d.phase = PH_CMD;
            ctl_d.oe    = 1'b0;
        end else begin
            if (sck_rise) begin
                ctl_d.rx = rx_next;
                if (ctl_q.cnt == CNT_W'(LAST_BIT)) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.phase == PH_CMD) begin
                        ctl_d.phase = PH_DATA;
                        ctl_d.rd    = rx_next[RD_BIT];
                        ctl_d.addr  = rx_next[ADDR_W-1:0];
                        tx_load     = rx_next[RD_BIT];
                    end else if (ctl_q.rd) begin
                        tx_load = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            if (sck_fall && ctl_q.phase == PH_DATA && ctl_q.rd) begin
                tx_shift = 1'b1;
                ctl_d.oe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cnt: '0, phase: PH_CMD, rd: 1'b0, addr: '0, rx: '0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    srp_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(ctl_q.addr), .wdata(rx_next),
        .raddr(rd_addr), .rdata(rd_data), .image(reg_image)
    );

    srp_txshift #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(tx_load), .load_val(rd_data), .shift(tx_shift),
        .lsb_first(order_lsb), .bit_o(tx_bit)
    );

    assign in_cmd  = (ctl_q.phase == PH_CMD);
    assign rd_flag = ctl_q.rd;
    assign ser_oe  = ctl_q.oe;
    assign ser_out = ctl_q.oe & tx_bit;

endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk #(
    parameter int IMG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_s,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             in_cmd,
    input logic             rd_flag,
    input logic             ser_oe,
    input logic             ser_out,
    input logic [IMG_W-1:0] reg_image
);
    p_oe_off_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !ser_oe);

    p_oe_off_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmd |-> !ser_oe);

    p_regs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(reg_image));

    p_cmd_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmd |=> $stable(reg_image));

    p_read_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && !in_cmd) |=> $stable(reg_image));

    p_out_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && !sck_fall && !sel_s) |=> $stable(ser_out));
endmodule

bind ser_reg_port ser_reg_port_chk #(.IMG_W((2**ADDR_W)*DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .in_cmd(in_cmd), .rd_flag(rd_flag),
    .ser_oe(ser_oe), .ser_out(ser_out), .reg_image(reg_image)
);

// File: tb/test_ser_reg_port.sv
module test_ser_reg_port;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NR   = 8;
    localparam int HALF = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, order_lsb, sel_n, ser_clk, ser_in;
    logic ser_out, ser_oe;
    logic [NR*DW-1:0] reg_image;

    ser_reg_port #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_ser_reg_port (
        .clk(clk), .rst_n(rst_n), .order_lsb(order_lsb), .sel_n(sel_n),
        .ser_clk(ser_clk), .ser_in(ser_in), .ser_out(ser_out),
        .ser_oe(ser_oe), .reg_image(reg_image)
    );

    int total = 0;
    int bad   = 0;
    int settle = 3;

    // behavioural reference state
    logic [7:0] m_regs [NR];
    bit rxq[$];
    bit txq[$];
    bit m_sel = 1'b1;
    bit m_cmd = 1'b1;
    bit m_rd  = 1'b0;
    int m_addr = 0;
    bit e_oe  = 1'b0;
    bit e_out = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_image();
        logic [63:0] img;
        for (int r = 0; r < NR; r++) img[r*DW +: DW] = m_regs[r];
        return img;
    endfunction

    function automatic void model_load(input logic [7:0] v);
        txq.delete();
        for (int i = 0; i < 8; i++) txq.push_back(order_lsb ? v[i] : v[7-i]);
    endfunction

    function automatic void model_rise(input bit v);
        logic [7:0] val;
        if (m_sel) return;
        rxq.push_back(v);
        if (rxq.size() == 8) begin
            for (int i = 0; i < 8; i++) val[order_lsb ? i : 7-i] = rxq[i];
            rxq.delete();
            if (m_cmd) begin
                m_cmd  = 1'b0;
                m_rd   = val[7];
                m_addr = int'(val[2:0]);
                if (m_rd) model_load(m_regs[m_addr]);
            end else if (m_rd) begin
                model_load(m_regs[m_addr]);
            end else begin
                m_regs[m_addr] = val;
            end
        end
    endfunction

    function automatic void model_fall();
        if (!m_sel && !m_cmd && m_rd && txq.size() > 0) begin
            e_out = txq.pop_front();
            e_oe  = 1'b1;
        end
    endfunction

    function automatic void model_release();
        m_sel = 1'b1;
        m_cmd = 1'b1;
        e_oe  = 1'b0;
        e_out = 1'b0;
        rxq.delete();
        txq.delete();
    endfunction

    // per-clock comparison against the reference model
    always @(posedge clk) begin
        #2;
        if (rst_n === 1'b1) begin
            if (settle > 0) settle--;
            if (settle == 0) begin
                chk(ser_oe === e_oe, "R5 enable per clock", 64'(ser_oe), 64'(e_oe));
                chk(ser_out === e_out, "R4 data out per clock", 64'(ser_out), 64'(e_out));
                chk(reg_image === model_image(), "R2/R10 register image per clock", reg_image, model_image());
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_low();
        @(negedge clk);
        sel_n = 1'b0; m_sel = 1'b0; settle = 3;
        wait_n(HALF);
    endtask

    task automatic sel_high();
        wait_n(HALF);
        sel_n = 1'b1; model_release(); settle = 3;
        wait_n(2*HALF);
    endtask

    task automatic xbit(input bit v, output bit got, output bit oe_seen);
        @(negedge clk);
        ser_in = v; settle = 3;
        wait_n(HALF);
        got = ser_out;
        oe_seen = ser_oe;
        ser_clk = 1'b1; model_rise(v); settle = 3;
        wait_n(HALF);
        ser_clk = 1'b0; model_fall(); settle = 3;
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] got, output bit oe_any);
        bit g, o;
        oe_any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int idx = order_lsb ? i : 7 - i;
            xbit(b[idx], g, o);
            got[idx] = g;
            oe_any |= o;
        end
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        logic [7:0] g; bit o;
        sel_low();
        xfer({5'b00000, 3'(a)}, g, o);
        xfer(v, g, o);
        sel_high();
    endtask

    task automatic rd(input int a, output logic [7:0] v, output bit cmd_oe);
        bit o;
        logic [7:0] g;
        sel_low();
        xfer({5'b10000, 3'(a)}, g, cmd_oe);
        xfer(8'h00, v, o);
        sel_high();
    endtask

    initial begin
        logic [7:0] g1, g2, gx;
        bit o1, o2, b;
        for (int r = 0; r < NR; r++) m_regs[r] = 8'h00;
        rst_n = 1'b0; order_lsb = 1'b0; sel_n = 1'b1; ser_clk = 1'b0; ser_in = 1'b0;
        wait_n(4);
        chk(ser_oe === 1'b0, "R1 reset enable", 64'(ser_oe), 0);
        chk(ser_out === 1'b0, "R1 reset data", 64'(ser_out), 0);
        chk(reg_image === '0, "R1 reset registers", reg_image, 0);
        rst_n = 1'b1; settle = 3;
        wait_n(4);

        // R2: plain write, MSB first
        wr(3, 8'hA5);
        chk(reg_image[3*DW +: DW] === 8'hA5, "R2 write reg3", 64'(reg_image[3*DW +: DW]), 64'hA5);

        // R3: command bits 6..3 set, still a write to register 5
        sel_low(); xfer(8'h7D, gx, o1); xfer(8'h3C, gx, o1); sel_high();
        chk(reg_image[5*DW +: DW] === 8'h3C, "R3 ignored bits write reg5", 64'(reg_image[5*DW +: DW]), 64'h3C);

        // R4/R5: read back, MSB first
        rd(3, g1, o1);
        chk(g1 === 8'hA5, "R4 read reg3 msb first", 64'(g1), 64'hA5);
        chk(o1 === 1'b0, "R5 enable low in command byte", 64'(o1), 0);
        chk(ser_oe === 1'b0, "R5 enable low after release", 64'(ser_oe), 0);

        // R6: raw bit order, MSB first: first bit 1 then zeros gives 0x80
        sel_low(); xfer(8'h07, gx, o1);
        for (int i = 0; i < 8; i++) xbit(i == 0, b, o2);
        sel_high();
        chk(reg_image[7*DW +: DW] === 8'h80, "R6 msb-first raw order", 64'(reg_image[7*DW +: DW]), 64'h80);

        // switch to LSB first between transactions
        order_lsb = 1'b1;
        wait_n(HALF);
        sel_low(); xfer(8'h04, gx, o1);
        for (int i = 0; i < 8; i++) xbit(i == 0, b, o2);
        sel_high();
        chk(reg_image[4*DW +: DW] === 8'h01, "R6 lsb-first raw order", 64'(reg_image[4*DW +: DW]), 64'h01);

        wr(6, 8'h1E);
        chk(reg_image[6*DW +: DW] === 8'h1E, "R6 lsb-first write reg6", 64'(reg_image[6*DW +: DW]), 64'h1E);
        rd(3, g1, o1);
        chk(g1 === 8'hA5, "R6 lsb-first read reg3", 64'(g1), 64'hA5);

        // R7/R9: three data bytes after one command, last looks like a read command
        sel_low(); xfer(8'h02, gx, o1); xfer(8'h11, gx, o1); xfer(8'h22, gx, o1); xfer(8'h83, gx, o1); sel_high();
        chk(reg_image[2*DW +: DW] === 8'h83, "R7 last byte wins reg2", 64'(reg_image[2*DW +: DW]), 64'h83);
        chk(reg_image[3*DW +: DW] === 8'hA5, "R9 command-like data byte not decoded", 64'(reg_image[3*DW +: DW]), 64'hA5);

        // R7: repeated read of same register
        sel_low(); xfer(8'h82, gx, o1); xfer(8'h00, g1, o1); xfer(8'h00, g2, o2); sel_high();
        chk(g1 === 8'h83, "R7 first read byte", 64'(g1), 64'h83);
        chk(g2 === 8'h83, "R7 second read byte", 64'(g2), 64'h83);
        chk(o1 === 1'b1, "R5 enable high in read data", 64'(o1), 1);

        // R8: partial data byte discarded
        order_lsb = 1'b0;
        wait_n(HALF);
        wr(1, 8'h5A);
        sel_low(); xfer(8'h01, gx, o1);
        for (int i = 0; i < 5; i++) xbit(1'b1, b, o2);
        sel_high();
        chk(reg_image[1*DW +: DW] === 8'h5A, "R8 partial byte dropped", 64'(reg_image[1*DW +: DW]), 64'h5A);

        // R10: a read leaves every register as it was
        rd(5, g1, o1);
        chk(g1 === 8'h3C, "R10 read reg5", 64'(g1), 64'h3C);
        chk(reg_image === model_image(), "R10 no register disturbed", reg_image, model_image());

        wait_n(8);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule